// File: doc/BRIEF.md
# Receiver Error Qualification and Sample Hold

This block sits behind the error detectors of a digital audio receiver. Each frame the detectors present seven error strobes alongside the decoded audio sample. The strobes cover parity, biphase coding, confidence, validity, loss of lock, channel-status CRC and Q-subcode CRC. A host-written enable register decides which of these errors count. Errors that count are collected in a sticky register that the host can read, drive an error pin for the frame, and hold an interrupt request. When the error can corrupt audio, it also triggers a substitution of the outgoing sample.

The host writes the enable register, and it is all zeros after reset, so no error counts until software opts in. The two CRC errors describe side-channel data, not audio. They are reported like any other error but never change the sample. The substitution policy is chosen by a two-bit hold mode. It can repeat the last clean sample, output silence, or let the damaged sample through.

Top module: `rx_err_qualify`

## Requirements
- R1: The enable register loads `en_wdata` on `en_wr`; bit 7 always reads 0 on `en_rdata`, and the register is 0x00 after reset.
- R2: An error whose enable bit is 0 sets no error register bit, does not drive `err_pin` or `irq`, and leaves the sample unchanged.
- R3: An enabled error sets its bit of the error register at the position of its enable bit (bit 0 parity, 1 biphase, 2 confidence, 3 validity, 4 unlock, 5 channel-status CRC, 6 Q-subcode CRC); set bits stay set across later frames.
- R4: `err_rd` clears the error register at the next clock edge; an enabled error arriving in that same cycle is kept.
- R5: `err_pin` is registered one cycle after each `frame_vld` and equals the OR of that frame's enabled errors; it holds between frames.
- R6: `irq` is high while any error register bit is set and drops once a read has cleared it.
- R7: With hold mode 2'b00, a frame with an enabled audio error (bits 0 to 4) outputs the last sample from a frame with no enabled audio error (zero after reset).
- R8: With hold mode 2'b01, a frame with an enabled audio error outputs zero.
- R9: With hold mode 2'b10 or 2'b11, a frame with an enabled audio error outputs its own sample unchanged.
- R10: Channel-status CRC and Q-subcode CRC errors never alter the output sample, whether enabled or not.
- R11: `err_in` has no effect while `frame_vld` is low.
- R12: `smp_out` and a one-cycle `smp_out_vld` appear one clock after `frame_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Host write strobe for the enable register |
| en_wdata | input | 8 | Enable register write value |
| en_rdata | output | 8 | Enable register readback |
| err_rd | input | 1 | Host read strobe; clears the error register |
| err_rdata | output | 8 | Sticky error register, bit 7 zero |
| frame_vld | input | 1 | Frame strobe: sample and error strobes valid |
| err_in | input | 7 | Per-frame error strobes |
| hold_mode | input | 2 | Substitution policy for damaged samples |
| smp_in | input | SMP_W | Received audio sample |
| smp_out | output | SMP_W | Qualified audio sample |
| smp_out_vld | output | 1 | Output sample valid |
| err_pin | output | 1 | Enabled-error indicator for the last frame |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong enable or error register bit shows on `err_rdata` and `irq` in the cycle after the frame that should have set or spared it. A stale or wrongly captured last-good sample shows only when a later damaged frame in repeat mode substitutes it, so the stimulus puts clean and damaged frames close together. CRC-only and masked frames are mixed with audio errors under every hold mode, so a wrong audio-error classification appears on `smp_out` one clock after the frame.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int NERR = 7;
  localparam int REG_W = 8;
  // errors that may corrupt the audio payload (parity..unlock)
  localparam logic [NERR-1:0] AUDIO_ERR = 7'b001_1111;

  typedef enum logic [1:0] {
    HOLD_REPEAT = 2'b00,
    HOLD_ZERO   = 2'b01,
    HOLD_PASS   = 2'b10,
    HOLD_PASS2  = 2'b11
  } hold_e;
endpackage

// File: rtl/rxq_enable_reg.sv
module rxq_enable_reg
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [NERR-1:0]  en_q
);
  logic [NERR-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (wr) en_d = wdata[NERR-1:0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_d;
  end

  // R1: a write is visible on the next cycle, top bit discarded
  a_r1_enable_write: assert property (@(posedge clk) disable iff (!rst_ni)
    wr |=> en_q == $past(wdata[NERR-1:0]));
endmodule

// File: rtl/rxq_err_capture.sv
module rxq_err_capture
  import rxq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            frame_vld,
  input  logic [NERR-1:0] err_in,
  input  logic [NERR-1:0] en_mask,
  input  logic            rd,
  output logic [NERR-1:0] err_q,
  output logic            pin_q,
  output logic            irq,
  output logic            audio_bad
);
  logic [NERR-1:0] hit;
  logic [NERR-1:0] hit_audio;
  logic [NERR-1:0] err_d;
  logic            pin_d;

  for (genvar i = 0; i < NERR; i++) begin : g_qual
    assign hit[i]       = frame_vld & err_in[i] & en_mask[i];
    assign hit_audio[i] = hit[i] & AUDIO_ERR[i];
  end

  assign audio_bad = |hit_audio;
  assign irq       = |err_q;

  always_comb begin
    err_d = (rd ? '0 : err_q) | hit;
    pin_d = pin_q;
    if (frame_vld) pin_d = |hit;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= '0;
      pin_q <= 1'b0;
    end else begin
      err_q <= err_d;
      pin_q <= pin_d;
    end
  end

  // R3: without a read, no captured bit is lost
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd |=> (err_q & $past(err_q)) == $past(err_q));
  // R2: newly set bits must all be enabled ones
  a_r2_suppressed: assert property (@(posedge clk) disable iff (!rst_ni)
    1'b1 |=> ((err_q & ~$past(err_q)) & ~$past(en_mask)) == '0);
  // R4: a read with no frame empties the register
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd && !frame_vld) |=> err_q == '0);
  // R11: pin only moves after a frame strobe
  a_r11_pin_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    !frame_vld |=> $stable(pin_q));
  // R6: interrupt rises only after a frame
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq) |-> $past(frame_vld));
endmodule

// File: rtl/rxq_sample_sub.sv
module rxq_sample_sub
  import rxq_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             frame_vld,
  input  logic             audio_bad,
  input  logic [1:0]       hold_mode,
  input  logic [SMP_W-1:0] smp_in,
  output logic [SMP_W-1:0] smp_q,
  output logic             vld_q
);
  logic [SMP_W-1:0] good_q, good_d, smp_d;
  logic             vld_d;
  hold_e            mode;

  assign mode = hold_e'(hold_mode);

  always_comb begin
    smp_d  = smp_q;
    good_d = good_q;
    vld_d  = frame_vld;
    if (frame_vld) begin
      if (!audio_bad) begin
        smp_d  = smp_in;
        good_d = smp_in;
      end else begin
        unique case (mode)
          HOLD_REPEAT: smp_d = good_q;
          HOLD_ZERO:   smp_d = '0;
          default:     smp_d = smp_in;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= '0;
      good_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      good_q <= good_d;
      vld_q  <= vld_d;
    end
  end

  // R10/R12: a frame without audio damage passes its sample one cycle later
  a_r10_clean_pass: assert property (@(posedge clk) disable iff (!rst_ni)
    (frame_vld && !audio_bad) |=> (vld_q && smp_q == $past(smp_in)));
  // R8: zero policy silences damaged frames
  a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rst_ni)
    (frame_vld && audio_bad && hold_mode == 2'b01) |=> smp_q == '0);
  // R12: output only changes on a frame
  a_r12_hold_between: assert property (@(posedge clk) disable iff (!rst_ni)
    !frame_vld |=> ($stable(smp_q) && !vld_q));
endmodule

// File: rtl/rx_err_qualify.sv
module rx_err_qualify
  import rxq_pkg::*;
#(
  parameter int SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic [7:0]       en_wdata,
  output logic [7:0]       en_rdata,
  input  logic             err_rd,
  output logic [7:0]       err_rdata,
  input  logic             frame_vld,
  input  logic [6:0]       err_in,
  input  logic [1:0]       hold_mode,
  input  logic [SMP_W-1:0] smp_in,
  output logic [SMP_W-1:0] smp_out,
  output logic             smp_out_vld,
  output logic             err_pin,
  output logic             irq
);
  localparam int PAD_W = REG_W - NERR;

  logic [1:0]      rst_sync_q;
  logic            rst_ni;
  logic [NERR-1:0] en_mask;
  logic [NERR-1:0] err_q;
  logic            audio_bad;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  rxq_enable_reg u_en (
    .clk    (clk),
    .rst_ni (rst_ni),
    .wr     (en_wr),
    .wdata  (en_wdata),
    .en_q   (en_mask)
  );

  rxq_err_capture u_cap (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .frame_vld (frame_vld),
    .err_in    (err_in),
    .en_mask   (en_mask),
    .rd        (err_rd),
    .err_q     (err_q),
    .pin_q     (err_pin),
    .irq       (irq),
    .audio_bad (audio_bad)
  );

  rxq_sample_sub #(.SMP_W(SMP_W)) u_sub (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .frame_vld (frame_vld),
    .audio_bad (audio_bad),
    .hold_mode (hold_mode),
    .smp_in    (smp_in),
    .smp_q     (smp_out),
    .vld_q     (smp_out_vld)
  );

  assign en_rdata  = {{PAD_W{1'b0}}, en_mask};
  assign err_rdata = {{PAD_W{1'b0}}, err_q};

  // R5: pin follows the enabled errors of the last frame
  a_r5_pin_frame: assert property (@(posedge clk) disable iff (!rst_ni)
    frame_vld |=> err_pin == |($past(err_in & en_mask)));
endmodule

// File: tb/rx_err_qualify_tb.sv
`timescale 1ns/1ps
module rx_err_qualify_tb;
  localparam int SMP_W = 24;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             en_wr;
  logic [7:0]       en_wdata;
  logic [7:0]       en_rdata;
  logic             err_rd;
  logic [7:0]       err_rdata;
  logic             frame_vld;
  logic [6:0]       err_in;
  logic [1:0]       hold_mode;
  logic [SMP_W-1:0] smp_in;
  logic [SMP_W-1:0] smp_out;
  logic             smp_out_vld;
  logic             err_pin;
  logic             irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  rx_err_qualify #(.SMP_W(SMP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .en_rdata(en_rdata), .err_rd(err_rd), .err_rdata(err_rdata),
    .frame_vld(frame_vld), .err_in(err_in), .hold_mode(hold_mode),
    .smp_in(smp_in), .smp_out(smp_out), .smp_out_vld(smp_out_vld),
    .err_pin(err_pin), .irq(irq)
  );

  typedef struct packed {
    logic [7:0]       en;
    logic [6:0]       err;
    logic [1:0]       hold;
    logic [SMP_W-1:0] smp;
    logic             pin;
    logic [6:0]       reg_v;
    logic [SMP_W-1:0] out;
  } vec_t;

  // each vector: write enable, clear register, one frame, check
  localparam vec_t VEC [11] = '{
    '{8'h00, 7'h7F, 2'd0, 24'h111111, 1'b0, 7'h00, 24'h111111}, // R2 all masked
    '{8'h7F, 7'h01, 2'd0, 24'h222222, 1'b1, 7'h01, 24'h111111}, // R7 repeat
    '{8'h7F, 7'h40, 2'd1, 24'h333333, 1'b1, 7'h40, 24'h333333}, // R10 QCRC
    '{8'h7F, 7'h20, 2'd0, 24'h444444, 1'b1, 7'h20, 24'h444444}, // R10 CCRC
    '{8'h7F, 7'h02, 2'd1, 24'h555555, 1'b1, 7'h02, 24'h000000}, // R8 zero
    '{8'h7F, 7'h04, 2'd2, 24'h666666, 1'b1, 7'h04, 24'h666666}, // R9 pass
    '{8'h7D, 7'h02, 2'd1, 24'h777777, 1'b0, 7'h00, 24'h777777}, // R2 one masked
    '{8'h10, 7'h18, 2'd0, 24'h888888, 1'b1, 7'h10, 24'h777777}, // R3 unlock
    '{8'hFF, 7'h08, 2'd0, 24'h999999, 1'b1, 7'h08, 24'h777777}, // R1 bit7
    '{8'h7F, 7'h00, 2'd0, 24'hABCDEF, 1'b0, 7'h00, 24'hABCDEF}, // R5 clean
    '{8'h60, 7'h61, 2'd1, 24'h123456, 1'b1, 7'h60, 24'h123456}  // R10 crc only
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_en(input logic [7:0] v);
    en_wr = 1'b1; en_wdata = v;
    tick();
    en_wr = 1'b0;
  endtask

  task automatic clear_err();
    err_rd = 1'b1;
    tick();
    err_rd = 1'b0;
  endtask

  task automatic frame(input logic [6:0] e, input logic [1:0] h, input logic [SMP_W-1:0] s);
    frame_vld = 1'b1; err_in = e; hold_mode = h; smp_in = s;
    tick();
    frame_vld = 1'b0; err_in = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    en_wr = 0; en_wdata = '0; err_rd = 0; frame_vld = 0;
    err_in = '0; hold_mode = '0; smp_in = '0;
    do_reset();
    check("R1 reset enable", en_rdata, 8'h00);
    check("R6 reset err", err_rdata, 8'h00);
    check("R6 reset irq", irq, 1'b0);
    check("R5 reset pin", err_pin, 1'b0);
    check("R12 reset vld", smp_out_vld, 1'b0);

    for (int i = 0; i < 11; i++) begin
      write_en(VEC[i].en);
      check("R1 readback", en_rdata, {1'b0, VEC[i].en[6:0]});
      clear_err();
      frame(VEC[i].err, VEC[i].hold, VEC[i].smp);
      check("R5 pin", err_pin, VEC[i].pin);
      check("R3 reg", err_rdata, {1'b0, VEC[i].reg_v});
      check("R6 irq", irq, |VEC[i].reg_v);
      check("R12 vld", smp_out_vld, 1'b1);
      check("R7/R8/R9/R10 sample", smp_out, VEC[i].out);
    end

    // sticky accumulation, last good now 123456
    write_en(8'h7F);
    clear_err();
    frame(7'h01, 2'd0, 24'h000001);
    frame(7'h08, 2'd0, 24'h000002);
    check("R3 sticky", err_rdata, 8'h09);
    check("R7 repeat held", smp_out, 24'h123456);
    frame(7'h00, 2'd0, 24'h000003);
    check("R5 pin drops", err_pin, 1'b0);
    check("R6 irq kept", irq, 1'b1);
    // errors without a frame strobe
    err_in = 7'h7F;
    tick();
    err_in = '0;
    check("R11 reg", err_rdata, 8'h09);
    check("R11 pin", err_pin, 1'b0);
    check("R12 no vld", smp_out_vld, 1'b0);
    check("R11 sample", smp_out, 24'h000003);
    clear_err();
    check("R4 cleared", err_rdata, 8'h00);
    check("R6 irq drop", irq, 1'b0);
    // read and new error in the same cycle
    err_rd = 1'b1;
    frame(7'h02, 2'd3, 24'hFEDCBA);
    err_rd = 1'b0;
    check("R4 same cycle", err_rdata, 8'h02);
    check("R9 pass alt", smp_out, 24'hFEDCBA);

    // reset mid-run, last good returns to zero
    do_reset();
    check("R1 reset again", en_rdata, 8'h00);
    check("R6 reset err again", err_rdata, 8'h00);
    check("R12 reset sample", smp_out, '0);
    write_en(8'h01);
    frame(7'h01, 2'd0, 24'h000005);
    check("R7 zero after reset", smp_out, 24'h000000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule